// File: doc/BRIEF.md
# Rotating Sector Position Counter

This block follows the angular position of a head-per-track rotating store. A free-running count of word times stands in for rotation: each pulse on the word strobe moves the position by one word. A revolution consists of a short overhead gap at the track start, followed by a whole number of fixed-size sectors. The block reports the following:

- the number of the next sector to reach the heads;
- the index of the current word within its sector;
- a phase flag that marks the closing words of each sector;
- a sticky flag that records the passing of the track origin;
- a one-cycle pulse when a chosen sector begins.

Two geometries are selected by a mode input. The disk geometry has many sectors, and its count reaches a terminal value equal to the sector total during the last sector. The drum geometry has fewer sectors, and its count falls back to zero for the last sector. As a result the zero state is short in disk mode and long in drum mode. The origin-passed flag is only reported in disk mode. It is cleared by a pulse and set again by the next track origin.

Top module: `rot_sector_counter`

## Requirements
- R1: After reset the next-sector count, word index, phase flag, origin flag and coincidence pulse are all 0, and the position is at the first gap word of the track.
- R2: A clock cycle with the word strobe low changes no output, except that the coincidence pulse is 0.
- R3: Each revolution starts with GAP_WORDS word times. During these the next-sector count and the word index both read 0.
- R4: With mode_i = 0 (disk), while sector s (0-based) is under the heads the count reads s+1, so the last sector reads DISK_SECS.
- R5: With mode_i = 1 (drum), while sector s is under the heads the count reads s+1, except that the last sector (DRUM_SECS-1) reads 0.
- R6: Within a sector the word index steps 0 to SEC_WORDS-1, one per strobe. A revolution is sectors*SEC_WORDS+GAP_WORDS strobes long and then repeats from the gap.
- R7: The phase flag is 1 exactly when the word index is in the last PHASE_WORDS words of a sector, and it is 0 in the gap.
- R8: In disk mode the origin flag sets on the strobe that leaves the last word of the last sector. A clear_origin_i pulse clears it, but a set in the same cycle takes priority.
- R9: In drum mode the origin flag output is always 0.
- R10: The coincidence output is 1 for exactly the one cycle after the strobe that enters word 0 of the sector whose 0-based number equals target_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_stb_i | input | 1 | One pulse per word time |
| mode_i | input | 1 | 0 = disk geometry, 1 = drum geometry |
| clear_origin_i | input | 1 | Clears the origin-passed flag |
| target_i | input | SEC_W | Sector number for coincidence |
| next_sec_o | output | SEC_W | Next sector to pass the heads |
| phase_o | output | 1 | Closing words of the sector |
| origin_o | output | 1 | Track origin passed since last clear |
| word_o | output | WORD_W | Word index within sector |
| coin_o | output | 1 | Target sector start pulse |

## Verification
The bench builds the block with SEC_WORDS=8, DISK_SECS=6, DRUM_SECS=4, GAP_WORDS=5 and PHASE_WORDS=3. A full revolution therefore takes 53 strobes in disk mode and 37 in drum mode. This puts several wraps, the terminal count of the disk geometry and the long zero state of the drum geometry within a short run. It also lets the bench place an origin clear on exactly the same strobe as the origin event, and put the coincidence target on both a middle sector and the last sector.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic {
    MODE_DISK = 1'b0,
    MODE_DRUM = 1'b1
  } rot_mode_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rsp_pos_track.sv
module rsp_pos_track
  import rsp_pkg::*;
#(
  parameter int unsigned SEC_WORDS = 64,
  parameter int unsigned DISK_SECS = 90,
  parameter int unsigned DRUM_SECS = 32,
  parameter int unsigned GAP_WORDS = 5,
  localparam int unsigned WORD_W = $clog2(SEC_WORDS),
  localparam int unsigned SEC_W  = $clog2(max_u(DISK_SECS, DRUM_SECS) + 1),
  localparam int unsigned GAP_W  = (GAP_WORDS > 1) ? $clog2(GAP_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_stb_i,
  input  rot_mode_e         mode_i,
  output logic              in_gap_o,
  output logic [WORD_W-1:0] word_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic              nxt_in_gap_o,
  output logic [WORD_W-1:0] nxt_word_o,
  output logic [SEC_W-1:0]  nxt_sec_o,
  output logic              origin_evt_o
);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(SEC_WORDS - 1);
  localparam logic [GAP_W-1:0]  LAST_GAP  = GAP_W'(GAP_WORDS - 1);

  logic              in_gap_q;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [WORD_W-1:0] word_q;
  logic [SEC_W-1:0]  sec_q;
  logic [SEC_W-1:0]  last_sec;
  logic              at_end;

  assign last_sec = (mode_i == MODE_DRUM) ? SEC_W'(DRUM_SECS - 1) : SEC_W'(DISK_SECS - 1);
  // >= keeps a mid-revolution mode change from running past the track
  assign at_end   = !in_gap_q && (word_q == LAST_WORD) && (sec_q >= last_sec);

  always_comb begin
    nxt_in_gap_o = in_gap_q;
    gap_d        = gap_q;
    nxt_word_o   = word_q;
    nxt_sec_o    = sec_q;
    if (in_gap_q) begin
      if (gap_q == LAST_GAP) begin
        nxt_in_gap_o = 1'b0;
        gap_d        = '0;
        nxt_word_o   = '0;
        nxt_sec_o    = '0;
      end else begin
        gap_d = gap_q + 1'b1;
      end
    end else if (word_q == LAST_WORD) begin
      nxt_word_o = '0;
      if (at_end) begin
        nxt_in_gap_o = 1'b1;
        gap_d        = '0;
        nxt_sec_o    = '0;
      end else begin
        nxt_sec_o = sec_q + 1'b1;
      end
    end else begin
      nxt_word_o = word_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_gap_q <= 1'b1;
      gap_q    <= '0;
      word_q   <= '0;
      sec_q    <= '0;
    end else if (word_stb_i) begin
      in_gap_q <= nxt_in_gap_o;
      gap_q    <= gap_d;
      word_q   <= nxt_word_o;
      sec_q    <= nxt_sec_o;
    end
  end

  assign in_gap_o     = in_gap_q;
  assign word_o       = word_q;
  assign sec_o        = sec_q;
  assign origin_evt_o = word_stb_i && at_end;

  a_r2_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_stb_i |=> $stable(word_q) && $stable(sec_q) && $stable(in_gap_q));

  a_r6_word_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_i && !in_gap_q && (word_q != LAST_WORD) |=> word_q == $past(word_q) + 1'b1);

  a_r6_sector_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_i && !in_gap_q && (word_q == LAST_WORD) && !at_end
      |=> (word_q == '0) && (sec_q == $past(sec_q) + 1'b1) && !in_gap_q);

  a_r3_gap_after_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    origin_evt_o |=> in_gap_q && (word_q == '0));
endmodule

// File: rtl/rsp_sector_decode.sv
module rsp_sector_decode
  import rsp_pkg::*;
#(
  parameter int unsigned SEC_WORDS   = 64,
  parameter int unsigned DISK_SECS   = 90,
  parameter int unsigned DRUM_SECS   = 32,
  parameter int unsigned PHASE_WORDS = 3,
  localparam int unsigned WORD_W = $clog2(SEC_WORDS),
  localparam int unsigned SEC_W  = $clog2(max_u(DISK_SECS, DRUM_SECS) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rot_mode_e         mode_i,
  input  logic              in_gap_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEC_W-1:0]  sec_i,
  output logic [SEC_W-1:0]  next_sec_o,
  output logic              phase_o
);
  localparam logic [WORD_W-1:0] PHASE_START = WORD_W'(SEC_WORDS - PHASE_WORDS);
  localparam logic [SEC_W-1:0]  DRUM_LAST   = SEC_W'(DRUM_SECS - 1);

  logic drum_wrap;
  assign drum_wrap = (mode_i == MODE_DRUM) && (sec_i >= DRUM_LAST);

  always_comb begin
    if (in_gap_i || drum_wrap) next_sec_o = '0;
    else                       next_sec_o = sec_i + 1'b1;
  end

  assign phase_o = !in_gap_i && (word_i >= PHASE_START);

  a_r3_gap_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_gap_i |-> (next_sec_o == '0) && !phase_o);

  a_r4_disk_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DISK) |-> next_sec_o <= SEC_W'(DISK_SECS));

  a_r5_drum_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DRUM) |-> next_sec_o < SEC_W'(DRUM_SECS));
endmodule

// File: rtl/rsp_origin_latch.sv
module rsp_origin_latch
  import rsp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  rot_mode_e mode_i,
  input  logic      origin_evt_i,
  input  logic      clear_i,
  output logic      origin_o
);
  logic flag_q;
  logic set_en;

  assign set_en = origin_evt_i && (mode_i == MODE_DISK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_en)  flag_q <= 1'b1;
    else if (clear_i) flag_q <= 1'b0;
  end

  assign origin_o = flag_q && (mode_i == MODE_DISK);

  a_r8_origin_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    origin_evt_i && (mode_i == MODE_DISK) |=> flag_q);

  a_r8_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !origin_evt_i |=> !flag_q);
endmodule

// File: rtl/rsp_coincidence.sv
module rsp_coincidence #(
  parameter int unsigned WORD_W = 6,
  parameter int unsigned SEC_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_stb_i,
  input  logic              nxt_in_gap_i,
  input  logic [WORD_W-1:0] nxt_word_i,
  input  logic [SEC_W-1:0]  nxt_sec_i,
  input  logic [SEC_W-1:0]  target_i,
  input  logic              in_gap_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              coin_o
);
  logic coin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coin_q <= 1'b0;
    else coin_q <= word_stb_i && !nxt_in_gap_i && (nxt_word_i == '0) && (nxt_sec_i == target_i);
  end

  assign coin_o = coin_q;

  a_r10_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_q |=> !coin_q);

  a_r10_at_sector_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_q |-> !in_gap_i && (word_i == '0));
endmodule

// File: rtl/rot_sector_counter.sv
module rot_sector_counter
  import rsp_pkg::*;
#(
  parameter int unsigned SEC_WORDS   = 64,
  parameter int unsigned DISK_SECS   = 90,
  parameter int unsigned DRUM_SECS   = 32,
  parameter int unsigned GAP_WORDS   = 5,
  parameter int unsigned PHASE_WORDS = 3,
  localparam int unsigned WORD_W = $clog2(SEC_WORDS),
  localparam int unsigned SEC_W  = $clog2(max_u(DISK_SECS, DRUM_SECS) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_stb_i,
  input  logic              mode_i,
  input  logic              clear_origin_i,
  input  logic [SEC_W-1:0]  target_i,
  output logic [SEC_W-1:0]  next_sec_o,
  output logic              phase_o,
  output logic              origin_o,
  output logic [WORD_W-1:0] word_o,
  output logic              coin_o
);
  rot_mode_e         mode;
  logic              in_gap, nxt_in_gap, origin_evt;
  logic [WORD_W-1:0] word, nxt_word;
  logic [SEC_W-1:0]  sec, nxt_sec;

  assign mode = rot_mode_e'(mode_i);

  rsp_pos_track #(
    .SEC_WORDS(SEC_WORDS), .DISK_SECS(DISK_SECS),
    .DRUM_SECS(DRUM_SECS), .GAP_WORDS(GAP_WORDS)
  ) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_stb_i(word_stb_i), .mode_i(mode),
    .in_gap_o(in_gap), .word_o(word), .sec_o(sec),
    .nxt_in_gap_o(nxt_in_gap), .nxt_word_o(nxt_word), .nxt_sec_o(nxt_sec),
    .origin_evt_o(origin_evt)
  );

  rsp_sector_decode #(
    .SEC_WORDS(SEC_WORDS), .DISK_SECS(DISK_SECS),
    .DRUM_SECS(DRUM_SECS), .PHASE_WORDS(PHASE_WORDS)
  ) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode),
    .in_gap_i(in_gap), .word_i(word), .sec_i(sec),
    .next_sec_o(next_sec_o), .phase_o(phase_o)
  );

  rsp_origin_latch u_origin (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode),
    .origin_evt_i(origin_evt), .clear_i(clear_origin_i), .origin_o(origin_o)
  );

  rsp_coincidence #(.WORD_W(WORD_W), .SEC_W(SEC_W)) u_coin (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_stb_i(word_stb_i),
    .nxt_in_gap_i(nxt_in_gap), .nxt_word_i(nxt_word), .nxt_sec_i(nxt_sec),
    .target_i(target_i), .in_gap_i(in_gap), .word_i(word), .coin_o(coin_o)
  );

  assign word_o = in_gap ? '0 : word;

  a_r9_drum_no_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> !origin_o);

  a_r7_phase_in_sector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o |-> word_o >= WORD_W'(SEC_WORDS - PHASE_WORDS));
endmodule

// File: tb/rot_sector_counter_bench.sv
module rot_sector_counter_bench;
  localparam int W = 8, DSK = 6, DRM = 4, GAP = 5, PH = 3;
  localparam int WORD_W = $clog2(W);
  localparam int SEC_W = $clog2(DSK + 1);

  typedef struct {
    int    due;
    int    cnt;
    bit    ph;
    bit    org;
    int    wd;
    bit    coin;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, stb = 0, mode = 0, clr = 0;
  logic [SEC_W-1:0]  target = '0;
  logic [SEC_W-1:0]  next_sec;
  logic              phase, origin, coin;
  logic [WORD_W-1:0] word;

  int   cyc = 0, checks = 0, errors = 0;
  exp_t q[$];
  int   m_pos = 0;
  bit   m_org = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rot_sector_counter #(.SEC_WORDS(W), .DISK_SECS(DSK), .DRUM_SECS(DRM),
                       .GAP_WORDS(GAP), .PHASE_WORDS(PH)) u_rot_sector_counter (
    .clk_i(clk), .rst_ni(rst_n), .word_stb_i(stb), .mode_i(mode),
    .clear_origin_i(clr), .target_i(target), .next_sec_o(next_sec),
    .phase_o(phase), .origin_o(origin), .word_o(word), .coin_o(coin));

  function automatic int secs();
    return mode ? DRM : DSK;
  endfunction

  function automatic int tlen();
    return secs() * W + GAP;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expected outputs for model position p
  function automatic exp_t model(int p, bit c, string tag);
    exp_t e;
    int s, w;
    e.tag = tag; e.coin = c; e.org = m_org && !mode;
    if (p < GAP) begin
      e.cnt = 0; e.ph = 0; e.wd = 0;
    end else begin
      s = (p - GAP) / W; w = (p - GAP) % W;
      e.wd = w; e.ph = (w >= W - PH);
      e.cnt = (mode && s == DRM - 1) ? 0 : s + 1;
    end
    return e;
  endfunction

  task automatic step(bit s, bit c);
    bit   cn, evt;
    exp_t e;
    string tag;
    @(negedge clk);
    stb = s; clr = c;
    cn = 0;
    evt = s && (m_pos == tlen() - 1);
    if (s) begin
      m_pos = (m_pos + 1) % tlen();
      cn = (m_pos >= GAP) && ((m_pos - GAP) % W == 0) && ((m_pos - GAP) / W == int'(target));
    end
    if (evt && !mode) m_org = 1;
    else if (c) m_org = 0;
    if (!s) tag = "R2";
    else if (m_pos < GAP) tag = "R3";
    else tag = mode ? "R5" : "R4";
    e = model(m_pos, cn, tag);
    e.due = cyc + 1;
    q.push_back(e);
    @(negedge clk);
    stb = 0; clr = 0;
  endtask

  // monitor: pop and compare expected items as they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk($sformatf("%s next_sec", e.tag), int'(next_sec), e.cnt);
      chk("R6 word", int'(word), e.wd);
      chk("R7 phase", int'(phase), int'(e.ph));
      chk(mode ? "R9 origin" : "R8 origin", int'(origin), int'(e.org));
      chk("R10 coin", int'(coin), int'(e.coin));
    end
  end

  task automatic do_reset(bit md, int tgt);
    @(negedge clk);
    rst_n = 0; mode = md; target = SEC_W'(tgt);
    repeat (3) @(negedge clk);
    m_pos = 0; m_org = 0;
    // R1: reset state
    chk("R1 next_sec", int'(next_sec), 0);
    chk("R1 word", int'(word), 0);
    chk("R1 phase", int'(phase), 0);
    chk("R1 origin", int'(origin), 0);
    chk("R1 coin", int'(coin), 0);
    rst_n = 1;
  endtask

  task automatic run_to(int p);
    while (m_pos != p) step(1, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // disk geometry, middle-sector target
    do_reset(0, 2);
    for (int i = 0; i < 2 * (DSK * W + GAP); i++) begin
      step(1, 0);
      if (i % 7 == 3) step(0, 0); // R2 idle cycle
    end
    step(0, 1);                   // R8 clear alone
    run_to(DSK * W + GAP - 1);
    step(1, 1);                   // R8 set beats clear on same strobe
    step(0, 0);
    step(0, 1);
    for (int i = 0; i < 20; i++) step(1, 0);
    // drum geometry, last-sector target
    do_reset(1, DRM - 1);
    for (int i = 0; i < 2 * (DRM * W + GAP) + 3; i++) begin
      step(1, (i % 11) == 0);     // R9 clears and origins never show
      if (i % 5 == 1) step(0, 0);
    end
    run_to(DRM * W + GAP - 1);
    step(1, 0);
    step(0, 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule